// File: doc/BRIEF.md
# Glitch-Free Clock Source Slice with Fractional Divider

This block turns a set of free-running clocks into one output clock. A small bank of auxiliary clocks feeds a plain selector that may glitch while it is being changed. Its output and a primary reference clock feed a two-input selector that switches without glitches by handing over on falling edges. The chosen clock then drives a divider whose divisor has 24 integer bits and 8 fraction bits, and the divider output passes through an enable gate. The gate opens and closes a few cycles of the chosen clock after the enable bit changes.

Software drives the slice through a small register port in the bus clock domain. It writes a control word and a divisor, and it reads back a one-hot status that shows which glitch-free input is actually driving the output. The safe order when changing the auxiliary source is: move the glitch-free selector to the reference, wait for the status, change the auxiliary choice, then move back.

The output is one pulse per divided period. Each pulse lasts the high phase of one chosen-clock cycle.

Top module: `clk_slice`

## Requirements
- R1: After reset the control word reads 0, the divisor reads 0x0000_0100, the status reads 1 (reference active), and clk_o stays low.
- R2: The control word at address 0 keeps only these fields, and all other bits read 0: glitch-free select in bits [1:0] (0 picks the reference, any nonzero value picks the auxiliary path), auxiliary select in bits [8:5], and enable in bit 11.
- R3: The status at address 2 is one-hot or zero. Bit 0 means the reference drives the output, and bit 1 means the auxiliary path does. The two glitch-free gates are never open together.
- R4: After the glitch-free select changes, the status moves to the new input once that input has taken over, and clk_o then follows the new input.
- R5: The auxiliary path carries aux_clk_i[k] for an auxiliary select value k below N_AUX. For larger values the path is held low, so a switch to it never completes, the status reads 0 and clk_o stays low.
- R6: The divisor at address 1 reads back as written. With a fraction of 0, clk_o pulses once every I cycles of the chosen clock, where I is the integer part in bits [31:8]. With I = 1, clk_o pulses every cycle.
- R7: A fraction F in bits [7:0] is accumulated once per period, and a carry adds one chosen-clock cycle to that period. The mean period is therefore I + F/256 cycles.
- R8: An integer part of 0 means 2^24 cycles, so no pulse appears for at least 2^24 cycles after the next reload.
- R9: Clearing the enable bit stops clk_o within about three chosen-clock cycles, with no partial pulse. Setting it again restarts the pulses at the programmed rate.
- R10: Writes to address 2 have no effect on any register. Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | register port clock |
| rst_ni | input | 1 | active-low asynchronous reset for all domains |
| ref_clk_i | input | 1 | primary reference clock, glitch-free input 0 |
| aux_clk_i | input | N_AUX | auxiliary clock sources |
| wr_en_i | input | 1 | write strobe |
| addr_i | input | 2 | register address: 0 control, 1 divisor, 2 status |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data for addr_i, combinational |
| clk_o | output | 1 | gated, divided output clock |

## Verification
The divider is swept over integer parts 1 to 6 with no fraction, then over three fractions on an integer part of 2. For each setting, output edges are counted over a fixed window and compared with window*256/(period*divisor). This separates a wrong reload count, a lost carry and an off-by-one on the pass-through case. Every auxiliary source is then selected in turn through the reference-first switching order, and their distinct periods show whether the selector has picked the right input. An out-of-range auxiliary select, an enable toggle, a zero integer part and writes to the read-only status cover the cases where the output must go quiet or a register must stay unchanged.

// File: rtl/clk_slice_pkg.sv
`timescale 1ns/1ps
package clk_slice_pkg;
  localparam int DATA_W    = 32;
  localparam int INT_W     = 24;
  localparam int FRAC_W    = 8;
  localparam int GSEL_LSB  = 0;
  localparam int GSEL_W    = 2;
  localparam int ASEL_LSB  = 5;
  localparam int ASEL_W    = 4;
  localparam int EN_BIT    = 11;
  localparam logic [DATA_W-1:0] DIV_RST = DATA_W'(1) << FRAC_W;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_DIV  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/clk_slice_regs.sv
`timescale 1ns/1ps
module clk_slice_regs
  import clk_slice_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [1:0]        gate_i,
  output logic              use_aux_o,
  output logic [ASEL_W-1:0] aux_sel_o,
  output logic              en_o,
  output logic [DATA_W-1:0] div_o
);
  logic [GSEL_W-1:0] gsel_q;
  logic [ASEL_W-1:0] asel_q;
  logic              en_q;
  logic [DATA_W-1:0] div_q;
  logic [1:0]        stat_s1_q, stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gsel_q <= '0;
      asel_q <= '0;
      en_q   <= 1'b0;
      div_q  <= DIV_RST;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_CTRL) begin
        gsel_q <= wdata_i[GSEL_LSB +: GSEL_W];
        asel_q <= wdata_i[ASEL_LSB +: ASEL_W];
        en_q   <= wdata_i[EN_BIT];
      end else if (addr_i == ADDR_DIV) begin
        div_q  <= wdata_i;
      end
    end
  end

  // status crosses from the source clocks into the bus domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_s1_q <= 2'b01;
      stat_q    <= 2'b01;
    end else begin
      stat_s1_q <= gate_i;
      stat_q    <= stat_s1_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[GSEL_LSB +: GSEL_W] = gsel_q;
        rdata_o[ASEL_LSB +: ASEL_W] = asel_q;
        rdata_o[EN_BIT]             = en_q;
      end
      ADDR_DIV:  rdata_o = div_q;
      ADDR_STAT: rdata_o[1:0] = stat_q;
      default:   rdata_o = '0;
    endcase
  end

  assign use_aux_o = |gsel_q;
  assign aux_sel_o = asel_q;
  assign en_o      = en_q;
  assign div_o     = div_q;

  assert_ctrl_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_CTRL) |=> (en_q == $past(wdata_i[EN_BIT])));

  assert_div_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_DIV) |=> (div_q == $past(wdata_i)));

  assert_stat_write_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_STAT) |=> ($stable(div_q) && $stable(en_q) && $stable(gsel_q)));

  assert_stat_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stat_q));
endmodule

// File: rtl/clk_slice_glmux.sv
`timescale 1ns/1ps
module clk_slice_glmux (
  input  logic       rst_ni,
  input  logic       ref_clk_i,
  input  logic       aux_clk_i,
  input  logic       use_aux_i,
  output logic [1:0] gate_o,
  output logic       clk_o
);
  logic [1:0] src_clk;
  logic [1:0] gate;
  assign src_clk = {aux_clk_i, ref_clk_i};

  for (genvar n = 0; n < 2; n++) begin : g_leg
    localparam int   OTHER = (n == 0) ? 1 : 0;
    localparam logic RST   = (n == 0);
    logic       want;
    logic [1:0] sync_q;
    logic       gate_q;

    // a leg may open only once the other leg has closed
    assign want = (use_aux_i == (n == 1)) && !gate[OTHER];

    always_ff @(posedge src_clk[n] or negedge rst_ni) begin
      if (!rst_ni) sync_q <= {RST, RST};
      else         sync_q <= {sync_q[0], want};
    end

    // gate moves only while this leg's clock is low
    always_ff @(negedge src_clk[n] or negedge rst_ni) begin
      if (!rst_ni) gate_q <= RST;
      else         gate_q <= sync_q[1];
    end

    assign gate[n] = gate_q;
  end

  assign gate_o = gate;
  assign clk_o  = |(src_clk & gate);

  assert_gates_exclusive_R3: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $onehot0(gate));
endmodule

// File: rtl/clk_slice_fdiv.sv
`timescale 1ns/1ps
module clk_slice_fdiv
  import clk_slice_pkg::*;
(
  input  logic                    clk_src_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [INT_W+FRAC_W-1:0] div_i,
  output logic                    clk_o
);
  localparam int CNT_W = INT_W + 1;

  logic [1:0]        en_s_q;
  logic [CNT_W-1:0]  rem_q, int_eff;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;
  logic              gate_q;
  logic              wrap;

  always_ff @(posedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni) en_s_q <= 2'b00;
    else         en_s_q <= {en_s_q[0], en_i};
  end

  assign int_eff = (div_i[FRAC_W +: INT_W] == '0) ? (CNT_W'(1) << INT_W)
                                                  : {1'b0, div_i[FRAC_W +: INT_W]};
  assign acc_sum = {1'b0, acc_q} + {1'b0, div_i[FRAC_W-1:0]};
  assign wrap    = (rem_q <= CNT_W'(1));

  // counting on the falling edge lets the gate change while the source is low
  always_ff @(negedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= CNT_W'(1);
      acc_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= wrap && en_s_q[1];
      if (wrap) begin
        acc_q <= acc_sum[FRAC_W-1:0];
        rem_q <= int_eff + CNT_W'(acc_sum[FRAC_W]);
      end else begin
        rem_q <= rem_q - CNT_W'(1);
      end
    end
  end

  assign clk_o = clk_src_i & gate_q;

  assert_no_pulse_disabled_R9: assert property (@(negedge clk_src_i) disable iff (!rst_ni)
    !en_s_q[1] |=> !gate_q);
endmodule

// File: rtl/clk_slice.sv
`timescale 1ns/1ps
module clk_slice
  import clk_slice_pkg::*;
#(
  parameter int N_AUX = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic [N_AUX-1:0]  aux_clk_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              clk_o
);
  logic              use_aux, en, aux_clk, sel_clk;
  logic [ASEL_W-1:0] aux_sel;
  logic [DATA_W-1:0] div;
  logic [1:0]        gate;

  clk_slice_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .gate_i    (gate),
    .use_aux_o (use_aux),
    .aux_sel_o (aux_sel),
    .en_o      (en),
    .div_o     (div)
  );

  // plain selector; out-of-range codes hold the path low
  always_comb begin
    aux_clk = 1'b0;
    for (int i = 0; i < N_AUX; i++)
      if (aux_sel == ASEL_W'(i)) aux_clk = aux_clk_i[i];
  end

  clk_slice_glmux u_glmux (
    .rst_ni    (rst_ni),
    .ref_clk_i (ref_clk_i),
    .aux_clk_i (aux_clk),
    .use_aux_i (use_aux),
    .gate_o    (gate),
    .clk_o     (sel_clk)
  );

  clk_slice_fdiv u_fdiv (
    .clk_src_i (sel_clk),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .div_i     (div),
    .clk_o     (clk_o)
  );
endmodule

// File: tb/clk_slice_bench.sv
`timescale 1ns/1ps
module clk_slice_bench;
  logic        clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0;
  logic [3:0]  aux = 4'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic        clk_o;
  int total = 0, bad = 0, edges = 0;
  int aux_per [4] = '{14, 22, 30, 46};

  always #5  clk = ~clk;
  always #20 ref_clk = ~ref_clk;
  always #7  aux[0] = ~aux[0];
  always #11 aux[1] = ~aux[1];
  always #15 aux[2] = ~aux[2];
  always #23 aux[3] = ~aux[3];

  clk_slice #(.N_AUX(4)) u_clk_slice (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .aux_clk_i(aux),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .clk_o(clk_o)
  );

  always @(posedge clk_o) edges = edges + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic measure(input int w, output int n);
    int c0;
    c0 = edges; #(w); n = edges - c0;
  endtask

  task automatic chk_rate(input int tsrc, input int dv, input string tag);
    int n, e;
    #400;
    measure(4000, n);
    e = (4000 * 256) / (tsrc * dv);
    check(n >= e - 1 && n <= e + 2, tag, n, e);
  endtask

  task automatic wait_sel(input logic [31:0] exp, input string tag);
    logic [31:0] d;
    bit one_ok = 1'b1;
    for (int i = 0; i < 300; i++) begin
      rd(2'd2, d);
      if (!$onehot0(d[1:0]) || d[31:2] != 0) one_ok = 1'b0;
      if (d == exp) break;
    end
    check(d == exp, tag, d, exp);
    check(one_ok, "R3 status one-hot while switching", one_ok, 1);
  endtask

  initial begin
    logic [31:0] d;
    int n;
    #33 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, d); check(d == 32'h0, "R1 ctrl reset", d, 0);
    rd(2'd1, d); check(d == 32'h100, "R1 div reset", d, 32'h100);
    rd(2'd2, d); check(d == 32'h1, "R1 status reset", d, 1);
    measure(500, n); check(n == 0, "R1 clk_o low", n, 0);

    // all-ones control: aux select 15 is out of range
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check(d == 32'h9E3, "R2 ctrl field mask", d, 32'h9E3);
    #1000;
    rd(2'd2, d); check(d == 32'h0, "R5 out-of-range aux never takes over", d, 0);
    measure(1000, n); check(n == 0, "R5 out-of-range aux output quiet", n, 0);

    wr(2'd0, 32'h800);
    wait_sel(32'h1, "R4 back to reference");
    rd(2'd0, d); check(d == 32'h800, "R2 ctrl readback enable only", d, 32'h800);

    for (int k = 1; k <= 6; k++) begin
      wr(2'd1, k << 8);
      chk_rate(40, k * 256, $sformatf("R6 integer divisor %0d", k));
    end
    for (int f = 1; f <= 3; f++) begin
      wr(2'd1, 32'h200 | (f * 64));
      chk_rate(40, 512 + f * 64, $sformatf("R7 fraction %0d/256", f * 64));
    end

    wr(2'd1, 32'h300);
    for (int a = 0; a < 4; a++) begin
      wr(2'd0, 32'h800 | (a << 5));
      wait_sel(32'h1, "R4 park on reference");
      wr(2'd0, 32'h801 | (a << 5));
      wait_sel(32'h2, "R4 aux takes over");
      chk_rate(aux_per[a], 32'h300, $sformatf("R5 aux source %0d", a));
    end

    wr(2'd0, 32'h800);
    wait_sel(32'h1, "R4 return to reference");
    wr(2'd1, 32'h100);
    chk_rate(40, 256, "R4 output follows reference");

    wr(2'd0, 32'h000);
    measure(200, n); check(n <= 5, "R9 stop within a few cycles", n, 5);
    measure(2000, n); check(n == 0, "R9 stopped", n, 0);
    wr(2'd0, 32'h800);
    chk_rate(40, 256, "R9 restart");

    wr(2'd1, 32'h0);
    #400;
    measure(3000, n); check(n == 0, "R8 zero integer means 2^24", n, 0);

    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); check(d == 32'h1, "R10 status unchanged", d, 1);
    rd(2'd0, d); check(d == 32'h800, "R10 ctrl unchanged", d, 32'h800);
    rd(2'd1, d); check(d == 32'h0, "R10 div unchanged", d, 0);
    rd(2'd3, d); check(d == 32'h0, "R10 addr 3 reads zero", d, 0);
    wr(2'd1, 32'hABCD_EF12);
    rd(2'd1, d); check(d == 32'hABCD_EF12, "R6 div readback", d, 32'hABCD_EF12);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog all-requirements act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule